// File: doc/BRIEF.md
# CRC-4 Multiframe Sa-Bit Buffer

This block stores the national (Sa4 to Sa8) bits for one complete 16-frame CRC-4 multiframe, once for each direction. Software writes five transmit bytes through a byte-wide register port. At the start of frame 1 those bytes are copied into a shadow store. While an odd-numbered frame is running, the framer names the Sa position it is about to send, and the block returns the matching bit from the shadow store. The framer also offers each received Sa bit together with a capture strobe. The block places those bits into a capture store that uses the same row and column layout. When a new multiframe starts, the whole capture store is moved into five readable receive bytes.

Each byte holds one Sa position. Byte 0 is Sa4 and byte 4 is Sa8. Bit k of a byte belongs to odd frame 2k+1, so bit 0 is frame 1 and bit 7 is frame 15. The framer supplies the current frame number and a one-cycle pulse in the first clock of every basic frame. A status register shows that a received multiframe has started and holds a sticky event bit. That event bit clears when the status register is read, and it raises an interrupt line when the interrupt enable is set. Software should write new transmit bytes during frame 0, after the multiframe event and before frame 1 begins.

Top module: `nbb_top`

## Requirements
- R1: After reset, all transmit, shadow, capture and receive bytes are zero. The status register reads zero, `irqOut` is low, and `txSaBit` and `txSaDrive` are low.
- R2: A write to address 0 to 4 stores `regWdata` in the transmit byte for Sa4 to Sa8 (address 0 is Sa4). A read with `regRe` returns the addressed byte on `regRdata` one clock later, and `regRdata` then holds that value until the next read.
- R3: The transmit bytes are copied into the shadow store on the clock edge where `frmStart` is high and `frmNum` is 1. A write at any other time does not change the transmitted bits until the next such copy.
- R4: When `bufEn` is high, `frmNum` is odd and `saSel` is 0 to 4, `txSaDrive` is 1 and `txSaBit` is bit (frmNum-1)/2 of the shadow byte for Sa position `saSel`. In every other case both outputs are 0.
- R5: A clock edge with `saRxValid` high, `frmNum` odd and `saSel` 0 to 4 stores `saRxBit` into bit (frmNum-1)/2 of capture row `saSel`. The capture store is not changed when the frame is even or when `saSel` is 5 to 7.
- R6: Receive bytes are read at addresses 8 to 12 (address 8 is Sa4). They take the capture contents only on the edge where `frmStart` is high and `frmNum` is 0, and they hold their value at all other times.
- R7: Status register address 13, bit 0, is high from the frame-0 start edge until the next `frmStart` edge.
- R8: Status bit 1 is set on every frame-0 start edge and stays set until address 13 is read. That read returns the value before clearing. If the set and the read fall on the same edge, the set wins.
- R9: `irqOut` equals status bit 1 AND `irqEn`.
- R10: Writes to addresses other than 0 to 4 change nothing. Reads of addresses 5 to 7, 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid one clock after `regRe` |
| frmStart | input | 1 | High for the first clock of each basic frame |
| frmNum | input | 4 | Number of the current basic frame, 0 to 15 |
| saSel | input | 3 | Current Sa position, 0 = Sa4 to 4 = Sa8 |
| saRxBit | input | 1 | Received Sa bit |
| saRxValid | input | 1 | Capture strobe for `saRxBit` |
| bufEn | input | 1 | Lets the buffer drive the transmit Sa bits |
| irqEn | input | 1 | Interrupt enable |
| txSaBit | output | 1 | Sa bit to transmit |
| txSaDrive | output | 1 | High when `txSaBit` comes from the buffer |
| irqOut | output | 1 | Interrupt request |

## Verification
A shadow byte that is loaded at the wrong edge shows up on `txSaBit` in the next odd frame. A late write is the sharpest probe, because it must stay invisible until the next frame-1 edge. A wrong row or column index shows up at once as a bit placed in the wrong frame. Capture errors stay hidden in the capture store until the following frame-0 edge, so a receive read in the middle of the multiframe must still return the previous snapshot. A read after that edge must show the new data. Faults in the sticky event bit show on `irqOut` within one clock and on the status byte at the next read.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int SA_COUNT   = 5;
  localparam int FRAMES     = 16;
  localparam int ODD_FRAMES = FRAMES / 2;
  localparam int BYTE_W     = ODD_FRAMES;
  localparam int FRM_W      = $clog2(FRAMES);
  localparam int COL_W      = $clog2(ODD_FRAMES);
  localparam int SA_SEL_W   = 3;
  localparam int ADDR_W     = 4;
  localparam int RX_BASE    = 8;
  localparam int STAT_ADDR  = RX_BASE + SA_COUNT;

  typedef logic [SA_COUNT-1:0][BYTE_W-1:0] saBuf_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_TX,
    RD_RX,
    RD_STAT
  } rdSrc_e;

  typedef struct packed {
    logic                txWr;
    logic [SA_SEL_W-1:0] idx;
    logic                loadShadow;
    logic                xferRx;
    logic                capEn;
    logic [SA_SEL_W-1:0] capRow;
    logic [COL_W-1:0]    capCol;
    rdSrc_e              rdSrc;
    logic                rdEn;
    logic                clrIrq;
    logic                frmStart;
  } ctlStb_t;
endpackage

// File: rtl/nbb_ctrl.sv
module nbb_ctrl
  import nbb_pkg::*;
(
  input  logic                regWe,
  input  logic                regRe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                frmStart,
  input  logic [FRM_W-1:0]    frmNum,
  input  logic [SA_SEL_W-1:0] saSel,
  input  logic                saRxValid,
  output ctlStb_t             stb
);
  localparam logic [ADDR_W-1:0]   TX_END   = ADDR_W'(SA_COUNT);
  localparam logic [ADDR_W-1:0]   RX_LO    = ADDR_W'(RX_BASE);
  localparam logic [ADDR_W-1:0]   RX_END   = ADDR_W'(RX_BASE + SA_COUNT);
  localparam logic [ADDR_W-1:0]   STAT_A   = ADDR_W'(STAT_ADDR);
  localparam logic [SA_SEL_W-1:0] SA_LIMIT = SA_SEL_W'(SA_COUNT);
  localparam logic [FRM_W-1:0]    FRM_ONE  = FRM_W'(1);

  logic              txHit;
  logic              rxHit;
  logic              statHit;
  logic [ADDR_W-1:0] rxOff;

  always_comb begin
    txHit   = regAddr < TX_END;
    rxHit   = (regAddr >= RX_LO) && (regAddr < RX_END);
    statHit = regAddr == STAT_A;
    rxOff   = regAddr - RX_LO;
  end

  always_comb begin
    stb            = '0;
    stb.frmStart   = frmStart;
    stb.txWr       = regWe && txHit;
    stb.idx        = txHit ? regAddr[SA_SEL_W-1:0] : rxOff[SA_SEL_W-1:0];
    stb.loadShadow = frmStart && (frmNum == FRM_ONE);
    stb.xferRx     = frmStart && (frmNum == '0);
    stb.capEn      = saRxValid && frmNum[0] && (saSel < SA_LIMIT);
    stb.capRow     = saSel;
    stb.capCol     = frmNum[FRM_W-1:1];
    stb.rdEn       = regRe;
    stb.clrIrq     = regRe && statHit;
    if (txHit)        stb.rdSrc = RD_TX;
    else if (rxHit)   stb.rdSrc = RD_RX;
    else if (statHit) stb.rdSrc = RD_STAT;
    else              stb.rdSrc = RD_NONE;
  end
endmodule

// File: rtl/nbb_dp.sv
module nbb_dp
  import nbb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStb_t             stb,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [SA_SEL_W-1:0] saSel,
  input  logic [FRM_W-1:0]    frmNum,
  input  logic                bufEn,
  input  logic                saRxBit,
  output logic                txSaBit,
  output logic                txSaDrive,
  output logic [BYTE_W-1:0]   rdData,
  output logic                irqStat,
  output logic                mfNow
);
  saBuf_t txReg;
  saBuf_t shadow;
  saBuf_t capReg;
  saBuf_t rxBuf;

  for (genvar r = 0; r < SA_COUNT; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txReg[r]  <= '0;
        shadow[r] <= '0;
        capReg[r] <= '0;
        rxBuf[r]  <= '0;
      end else begin
        if (stb.txWr && stb.idx == SA_SEL_W'(r)) txReg[r] <= wrData;
        if (stb.loadShadow) shadow[r] <= txReg[r];
        if (stb.capEn && stb.capRow == SA_SEL_W'(r)) capReg[r][stb.capCol] <= saRxBit;
        if (stb.xferRx) rxBuf[r] <= capReg[r];
      end
    end
  end

  always_comb begin
    txSaDrive = 1'b0;
    txSaBit   = 1'b0;
    for (int i = 0; i < SA_COUNT; i++) begin
      if (bufEn && frmNum[0] && saSel == SA_SEL_W'(i)) begin
        txSaDrive = 1'b1;
        txSaBit   = shadow[i][frmNum[FRM_W-1:1]];
      end
    end
  end

  function automatic logic [BYTE_W-1:0] pickRow(saBuf_t b, logic [SA_SEL_W-1:0] i);
    logic [BYTE_W-1:0] v;
    v = '0;
    for (int k = 0; k < SA_COUNT; k++) begin
      if (i == SA_SEL_W'(k)) v = b[k];
    end
    return v;
  endfunction

  logic [BYTE_W-1:0] rdNext;

  always_comb begin
    unique case (stb.rdSrc)
      RD_TX:   rdNext = pickRow(txReg, stb.idx);
      RD_RX:   rdNext = pickRow(rxBuf, stb.idx);
      RD_STAT: rdNext = {{(BYTE_W-2){1'b0}}, irqStat, mfNow};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      irqStat <= 1'b0;
      mfNow   <= 1'b0;
    end else begin
      if (stb.rdEn) rdData <= rdNext;
      if (stb.xferRx) irqStat <= 1'b1;
      else if (stb.clrIrq) irqStat <= 1'b0;
      if (stb.xferRx) mfNow <= 1'b1;
      else if (stb.frmStart) mfNow <= 1'b0;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadShadow |=> $stable(shadow)); // R3
  AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xferRx |=> $stable(rxBuf)); // R6
  AST_MF_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mfNow) |-> $past(stb.xferRx)); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.xferRx |=> irqStat); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrIrq && !stb.xferRx) |=> !irqStat); // R8
endmodule

// File: rtl/nbb_top.sv
module nbb_top
  import nbb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWdata,
  output logic [BYTE_W-1:0]   regRdata,
  input  logic                frmStart,
  input  logic [FRM_W-1:0]    frmNum,
  input  logic [SA_SEL_W-1:0] saSel,
  input  logic                saRxBit,
  input  logic                saRxValid,
  input  logic                bufEn,
  input  logic                irqEn,
  output logic                txSaBit,
  output logic                txSaDrive,
  output logic                irqOut
);
  ctlStb_t stb;
  logic    irqStat;
  logic    mfNow;

  nbb_ctrl i_ctrl (
    .regWe     (regWe),
    .regRe     (regRe),
    .regAddr   (regAddr),
    .frmStart  (frmStart),
    .frmNum    (frmNum),
    .saSel     (saSel),
    .saRxValid (saRxValid),
    .stb       (stb)
  );

  nbb_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWdata),
    .saSel     (saSel),
    .frmNum    (frmNum),
    .bufEn     (bufEn),
    .saRxBit   (saRxBit),
    .txSaBit   (txSaBit),
    .txSaDrive (txSaDrive),
    .rdData    (regRdata),
    .irqStat   (irqStat),
    .mfNow     (mfNow)
  );

  assign irqOut = irqStat && irqEn;

  AST_TX_QUIET_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    !frmNum[0] |-> (!txSaDrive && !txSaBit)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut); // R9
endmodule

// File: tb/test_nbb_top.sv
module test_nbb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0, regRe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       frmStart = 1'b0;
  logic [3:0] frmNum = '0;
  logic [2:0] saSel = '0;
  logic       saRxBit = 1'b0, saRxValid = 1'b0;
  logic       bufEn = 1'b0, irqEn = 1'b0;
  logic       txSaBit, txSaDrive, irqOut;

  nbb_top i_nbb_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .frmStart(frmStart), .frmNum(frmNum),
    .saSel(saSel), .saRxBit(saRxBit), .saRxValid(saRxValid), .bufEn(bufEn),
    .irqEn(irqEn), .txSaBit(txSaBit), .txSaDrive(txSaDrive), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [7:0] txM [5];
  logic [7:0] shM [5];
  logic [7:0] capM [5];
  logic [7:0] rxM [5];
  logic irqM = 1'b0;
  logic mfM = 1'b0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(int a);
    if (a < 5) return txM[a];
    if (a >= 8 && a < 13) return rxM[a-8];
    if (a == 13) return {6'b0, irqM, mfM};
    return 8'h00;
  endfunction

  task automatic startFrame(int f);
    frmStart = 1'b1;
    frmNum = 4'(f);
    @(negedge clk);
    frmStart = 1'b0;
    if (f == 1) for (int i = 0; i < 5; i++) shM[i] = txM[i];
    if (f == 0) begin
      for (int i = 0; i < 5; i++) rxM[i] = capM[i];
      irqM = 1'b1;
      mfM = 1'b1;
    end else mfM = 1'b0;
  endtask

  task automatic regWrite(int a, logic [7:0] d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (a < 5) txM[a] = d;
  endtask

  task automatic regRead(int a, string req);
    logic [7:0] e;
    e = expRead(a);
    regRe = 1'b1; regAddr = 4'(a);
    @(negedge clk);
    regRe = 1'b0;
    chk(req, regRdata, e);
    if (a == 13) irqM = 1'b0;
  endtask

  task automatic saStep(int s, int f, logic en, logic vld, logic b);
    logic e;
    saSel = 3'(s); bufEn = en; saRxValid = vld; saRxBit = b;
    #1;
    e = (en && f[0] && s < 5) ? shM[s][f>>1] : 1'b0;
    chk("R4 txSaBit", {7'b0, txSaBit}, {7'b0, e});
    chk("R4 txSaDrive", {7'b0, txSaDrive}, {7'b0, (en && f[0] && s < 5)});
    @(negedge clk);
    saRxValid = 1'b0;
    if (vld && f[0] && s < 5) capM[s][f>>1] = b;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) begin txM[i] = 0; shM[i] = 0; capM[i] = 0; rxM[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) regRead(a, "R1 reset read");
    chk("R1 irqOut", {7'b0, irqOut}, 8'h00);
    chk("R1 txSaDrive", {7'b0, txSaDrive}, 8'h00);
    // R10 ignored writes and unmapped reads
    regWrite(9, 8'hA5); regWrite(13, 8'hFF); regWrite(6, 8'h3C); regWrite(15, 8'h77);
    regRead(9, "R10 rx write ignored");
    regRead(13, "R10 status write ignored");
    regRead(6, "R10 unmapped read");
    regRead(15, "R10 unmapped read");
    // R2 directed write/readback of every tx byte
    for (int a = 0; a < 5; a++) regWrite(a, 8'(8'h11 * (a + 1)));
    for (int a = 0; a < 5; a++) regRead(a, "R2 tx readback");
    chk("R2 rdata holds", regRdata, txM[4]);

    for (int mf = 0; mf < 8; mf++) begin
      irqEn = mf[0];
      for (int f = 0; f < 16; f++) begin
        startFrame(f);
        chk("R9 irqOut", {7'b0, irqOut}, {7'b0, irqM & irqEn});
        if (f == 0) begin
          regRead(13, "R7 R8 status at frame 0");
          if (mf == 2) regRead(13, "R8 cleared by read");
          for (int a = 0; a < 5; a++)
            if ($urandom_range(1, 0) == 1) regWrite(a, 8'($urandom));
          for (int a = 8; a < 13; a++) regRead(a, "R6 rx after frame 0");
        end
        if (f == 5 || f == 12) begin
          regWrite($urandom_range(4, 0), 8'($urandom));
          regRead($urandom_range(4, 0), "R2 tx readback");
        end
        if (f == 8) begin
          for (int a = 8; a < 13; a++) regRead(a, "R6 rx held mid multiframe");
          regRead(13, "R7 R8 status mid multiframe");
        end
        for (int s = 0; s < 7; s++)
          saStep(s, f, logic'($urandom_range(3, 0) != 0), logic'($urandom_range(1, 0)),
                 logic'($urandom_range(1, 0)));
        chk("R9 irqOut in frame", {7'b0, irqOut}, {7'b0, irqM & irqEn});
      end
    end
    // R5 R6: final transfer exposes all captured bits
    startFrame(0);
    for (int a = 8; a < 13; a++) regRead(a, "R5 capture layout");
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule